// File: doc/BRIEF.md
# Control Endpoint Status Controller

This block keeps the handshake state of a USB device's control endpoint. It sits between the serial interface engine, which reports decoded packet events, and the firmware, which reads and writes a small register window. From these two sides it maintains the setup, OUT, transmit-ready and transmit-complete flags, the direction bit, a stall request, and separate DATA0/DATA1 toggles for each direction. For every SETUP, OUT or IN event it chooses the handshake the engine sends back: ACK, NAK, STALL, or a data packet with a given parity. It also says whether the engine keeps the received bytes in the endpoint FIFO.

Only one event pulse arrives per cycle. The response comes back as a single-cycle notification one clock after the event. It has no ready signal, so the engine must take it in that cycle and cannot apply back-pressure. The FIFO storage is outside the block. Firmware frees the FIFO by clearing the setup or OUT flag, and the block signals this with a one-cycle `fifo_clr` pulse. An interrupt line combines the three hardware-set flags with their enable bits.

Top module: `ctl_ep_status`

## Requirements
- R1: A SETUP event always gets response code ACK (0) with `rsp_keep`=1 and sets the setup flag (status bit 0). It never sets the OUT flag (status bit 1), and this holds even when the setup flag is already set.
- R2: In the same update, a SETUP clears the OUT flag (bit 1), transmit-complete (bit 2), transmit-ready (bit 3), direction (bit 4) and stall request (bit 5).
- R3: While the setup flag is set, OUT and IN events get NAK (1) with `rsp_keep`=0. If a firmware write of 0 to bit 0 clears a set setup flag, `fifo_clr` pulses for one cycle after the write. A write that clears no set flag leaves `fifo_clr` low.
- R4: The direction bit (bit 4) holds the value firmware last wrote and reads back at address 0. A SETUP resets it to 0.
- R5: An IN event gets STALL (2) when the stall bit is set. Otherwise it gets DATA (3), with `rsp_odd` equal to the IN toggle (bit 6), when transmit-ready is set and transmit-complete is clear. In all other cases it gets NAK (1). Writing 1 to bit 3 sets transmit-ready, and writing 0 to bit 3 has no effect.
- R6: A host ACK that follows a DATA response sets transmit-complete, clears transmit-ready and inverts the IN toggle. A host ACK with no DATA outstanding changes nothing.
- R7: When an OUT event's parity `sie_out_odd` equals the OUT toggle (bit 7) and the setup and OUT flags are both clear, it gets ACK with `rsp_keep`=1, sets the OUT flag and inverts the OUT toggle. Writing 0 to bit 1 clears a set OUT flag and pulses `fifo_clr`.
- R8: An OUT event that arrives while the OUT flag is set gets NAK with `rsp_keep`=0 and leaves the status unchanged.
- R9: An OUT event whose parity does not match the OUT toggle gets ACK with `rsp_keep`=0 and changes neither the flags nor the toggles.
- R10: A SETUP sets both the IN and OUT toggles to 1 (DATA1). After reset both toggles are 0.
- R11: `irq` is high while any of setup, OUT or transmit-complete is set and its enable bit at address 1 (bits 0, 1, 2 in that order) is set. It stays high until firmware clears the flag or the enable.
- R12: `rsp_valid` is high exactly in the cycle after each SETUP, OUT or IN event and is low at all other times, including after reset and after host ACK events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sie_setup | input | 1 | Valid SETUP data packet received |
| sie_out | input | 1 | Valid OUT data packet received |
| sie_out_odd | input | 1 | Parity of that OUT packet (1 = DATA1) |
| sie_in | input | 1 | IN token received |
| sie_ack | input | 1 | Host ACK for the last IN data packet |
| rsp_valid | output | 1 | Response notification, one cycle |
| rsp_code | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| rsp_odd | output | 1 | Parity for a DATA response |
| rsp_keep | output | 1 | Received bytes stay in the FIFO |
| cfg_we | input | 1 | Firmware register write strobe |
| cfg_addr | input | AW | Register address (0 status, 1 enables) |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` |
| fifo_clr | output | 1 | FIFO release pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the ones that need two packet events and a firmware write in a precise order. Examples are a second IN data packet whose parity has already been flipped by a host ACK, and the zero-length status OUT that must still find its toggle at DATA1 after a full IN data stage. The stimulus walks through complete control-read and control-write transfers and reads the status register between steps. It then adds a mismatched OUT parity, a spare host ACK, and a SETUP that arrives while stall, direction and transmit-ready are all set.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_DATA  = 2'd3
  } hs_e;

  // status register bit positions
  localparam int ST_SETUP = 0;
  localparam int ST_OUT   = 1;
  localparam int ST_CMPL  = 2;
  localparam int ST_TXRDY = 3;
  localparam int ST_DIR   = 4;
  localparam int ST_STALL = 5;
  localparam int ST_TGIN  = 6;
  localparam int ST_TGOUT = 7;
  localparam int ST_W     = 8;

  localparam int REG_STATUS = 0;
  localparam int REG_IEN    = 1;
  localparam int NFLAG      = 3;
endpackage

// File: rtl/ep_flags.sv
module ep_flags
  import ctl_ep_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_setup,
  input  logic          ev_out_take,
  input  logic          ev_in_done,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  output logic          rx_setup,
  output logic          rx_out,
  output logic          tx_cmpl,
  output logic          tx_rdy,
  output logic          dir_q,
  output logic          stall_q,
  output logic          fifo_clr
);
  logic n_setup, n_out, n_cmpl, n_rdy, n_dir, n_stall, n_clr;
  logic wdata_unused;
  assign wdata_unused = ^{wdata[DW-1:ST_TGIN]};

  always_comb begin
    n_setup = rx_setup;
    n_out   = rx_out;
    n_cmpl  = tx_cmpl;
    n_rdy   = tx_rdy;
    n_dir   = dir_q;
    n_stall = stall_q;
    n_clr   = 1'b0;
    if (wr_stat) begin
      if (!wdata[ST_SETUP] && rx_setup) begin
        n_setup = 1'b0;
        n_clr   = 1'b1;
      end
      if (!wdata[ST_OUT] && rx_out) begin
        n_out = 1'b0;
        n_clr = 1'b1;
      end
      if (!wdata[ST_CMPL]) n_cmpl = 1'b0;
      if (wdata[ST_TXRDY]) n_rdy = 1'b1;
      n_dir   = wdata[ST_DIR];
      n_stall = wdata[ST_STALL];
    end
    if (ev_out_take) n_out = 1'b1;
    if (ev_in_done) begin
      n_cmpl = 1'b1;
      n_rdy  = 1'b0;
    end
    if (ev_setup) begin
      n_setup = 1'b1;
      n_out   = 1'b0;
      n_cmpl  = 1'b0;
      n_rdy   = 1'b0;
      n_dir   = 1'b0;
      n_stall = 1'b0;
      n_clr   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_setup <= 1'b0;
      rx_out   <= 1'b0;
      tx_cmpl  <= 1'b0;
      tx_rdy   <= 1'b0;
      dir_q    <= 1'b0;
      stall_q  <= 1'b0;
      fifo_clr <= 1'b0;
    end else begin
      rx_setup <= n_setup;
      rx_out   <= n_out;
      tx_cmpl  <= n_cmpl;
      tx_rdy   <= n_rdy;
      dir_q    <= n_dir;
      stall_q  <= n_stall;
      fifo_clr <= n_clr;
    end
  end
endmodule

// File: rtl/ep_toggle.sv
module ep_toggle #(
  parameter int NDIR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_setup,
  input  logic [NDIR-1:0] flip,
  output logic [NDIR-1:0] tog
);
  for (genvar i = 0; i < NDIR; i++) begin : g_tog
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tog[i] <= 1'b0;
      else if (ev_setup) tog[i] <= 1'b1;
      else if (flip[i])  tog[i] <= ~tog[i];
    end
  end
endmodule

// File: rtl/ep_hs.sv
module ep_hs
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sie_setup,
  input  logic       sie_out,
  input  logic       sie_out_odd,
  input  logic       sie_in,
  input  logic       sie_ack,
  input  logic       rx_setup,
  input  logic       rx_out,
  input  logic       tx_cmpl,
  input  logic       tx_rdy,
  input  logic       stall_q,
  input  logic       tog_in,
  input  logic       tog_out,
  output logic       ev_out_take,
  output logic       ev_in_done,
  output logic       rsp_valid,
  output logic [1:0] rsp_code,
  output logic       rsp_odd,
  output logic       rsp_keep
);
  logic pending;
  logic in_data, out_busy;
  hs_e  code_n;
  logic keep_n, odd_n;

  assign out_busy    = rx_setup | rx_out;
  assign ev_out_take = sie_out && !out_busy && (sie_out_odd == tog_out);
  assign in_data     = sie_in && !stall_q && tx_rdy && !tx_cmpl && !rx_setup;
  assign ev_in_done  = sie_ack && pending;

  always_comb begin
    code_n = HS_NAK;
    keep_n = 1'b0;
    odd_n  = 1'b0;
    if (sie_setup) begin
      code_n = HS_ACK;
      keep_n = 1'b1;
    end else if (sie_out) begin
      if (!out_busy) begin
        code_n = HS_ACK;
        keep_n = ev_out_take;
      end
    end else if (sie_in) begin
      if (stall_q) code_n = HS_STALL;
      else if (in_data) begin
        code_n = HS_DATA;
        odd_n  = tog_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_code  <= HS_ACK;
      rsp_odd   <= 1'b0;
      rsp_keep  <= 1'b0;
    end else begin
      if (sie_setup || sie_ack) pending <= 1'b0;
      else if (in_data)         pending <= 1'b1;
      rsp_valid <= sie_setup | sie_out | sie_in;
      rsp_code  <= code_n;
      rsp_odd   <= odd_n;
      rsp_keep  <= keep_n;
    end
  end
endmodule

// File: rtl/ep_irq.sv
module ep_irq #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [NF-1:0] wdata,
  input  logic [NF-1:0] flags,
  output logic [NF-1:0] ien,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ien <= '0;
    else if (wr_en) ien <= wdata;
  end
  assign irq = |(flags & ien);
endmodule

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
  import ctl_ep_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sie_setup,
  input  logic          sie_out,
  input  logic          sie_out_odd,
  input  logic          sie_in,
  input  logic          sie_ack,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic          rsp_odd,
  output logic          rsp_keep,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          fifo_clr,
  output logic          irq
);
  localparam int NDIR = 2;

  logic rx_setup, rx_out, tx_cmpl, tx_rdy, dir_q, stall_q;
  logic tog_in, tog_out;
  logic ev_out_take, ev_in_done;
  logic [NDIR-1:0] tog, flip;
  logic [NFLAG-1:0] ien;
  logic [ST_W-1:0] status;
  logic wr_stat, wr_ien;

  assign wr_stat = cfg_we && (cfg_addr == AW'(REG_STATUS));
  assign wr_ien  = cfg_we && (cfg_addr == AW'(REG_IEN));

  ep_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev_setup(sie_setup),
    .ev_out_take(ev_out_take), .ev_in_done(ev_in_done),
    .wr_stat(wr_stat), .wdata(cfg_wdata),
    .rx_setup(rx_setup), .rx_out(rx_out), .tx_cmpl(tx_cmpl),
    .tx_rdy(tx_rdy), .dir_q(dir_q), .stall_q(stall_q), .fifo_clr(fifo_clr)
  );

  assign flip    = {ev_out_take, ev_in_done};
  assign tog_in  = tog[0];
  assign tog_out = tog[1];

  ep_toggle #(.NDIR(NDIR)) u_tog (
    .clk(clk), .rst_n(rst_n), .ev_setup(sie_setup), .flip(flip), .tog(tog)
  );

  ep_hs u_hs (
    .clk(clk), .rst_n(rst_n), .sie_setup(sie_setup), .sie_out(sie_out),
    .sie_out_odd(sie_out_odd), .sie_in(sie_in), .sie_ack(sie_ack),
    .rx_setup(rx_setup), .rx_out(rx_out), .tx_cmpl(tx_cmpl), .tx_rdy(tx_rdy),
    .stall_q(stall_q), .tog_in(tog_in), .tog_out(tog_out),
    .ev_out_take(ev_out_take), .ev_in_done(ev_in_done),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_odd(rsp_odd),
    .rsp_keep(rsp_keep)
  );

  ep_irq #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ien), .wdata(cfg_wdata[NFLAG-1:0]),
    .flags({tx_cmpl, rx_out, rx_setup}), .ien(ien), .irq(irq)
  );

  always_comb begin
    status           = '0;
    status[ST_SETUP] = rx_setup;
    status[ST_OUT]   = rx_out;
    status[ST_CMPL]  = tx_cmpl;
    status[ST_TXRDY] = tx_rdy;
    status[ST_DIR]   = dir_q;
    status[ST_STALL] = stall_q;
    status[ST_TGIN]  = tog_in;
    status[ST_TGOUT] = tog_out;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(REG_STATUS))   cfg_rdata[ST_W-1:0]  = status;
    else if (cfg_addr == AW'(REG_IEN)) cfg_rdata[NFLAG-1:0] = ien;
  end
endmodule

// File: rtl/ctl_ep_checker.sv
module ctl_ep_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sie_setup,
  input logic       sie_out,
  input logic       sie_in,
  input logic       sie_ack,
  input logic       rsp_valid,
  input logic [1:0] rsp_code,
  input logic       rsp_keep,
  input logic       rx_setup,
  input logic       rx_out,
  input logic       tx_cmpl,
  input logic       tx_rdy,
  input logic       dir_q,
  input logic       stall_q,
  input logic       tog_in,
  input logic       tog_out
);
  logic any_ev;
  assign any_ev = sie_setup | sie_out | sie_in;

  assert_single_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sie_setup, sie_out, sie_in, sie_ack}) <= 1);

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> rsp_valid);

  assert_rsp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ev |=> !rsp_valid);

  assert_setup_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup |=> rx_setup && !rx_out && !tx_cmpl && !tx_rdy && !dir_q && !stall_q);

  assert_setup_data1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup |=> tog_in && tog_out);

  assert_in_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sie_in && !stall_q && !tx_rdy |=> rsp_code == 2'd1);

  assert_out_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sie_out && rx_out |=> rsp_code == 2'd1 && !rsp_keep && rx_out && $stable(tog_out));
endmodule

bind ctl_ep_status ctl_ep_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sie_setup(sie_setup), .sie_out(sie_out),
  .sie_in(sie_in), .sie_ack(sie_ack), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .rsp_keep(rsp_keep), .rx_setup(rx_setup),
  .rx_out(rx_out), .tx_cmpl(tx_cmpl), .tx_rdy(tx_rdy), .dir_q(dir_q),
  .stall_q(stall_q), .tog_in(tog_in), .tog_out(tog_out)
);

// File: tb/sim_ctl_ep_status.sv
`timescale 1ns/1ps
module sim_ctl_ep_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sie_setup = 0, sie_out = 0, sie_out_odd = 0, sie_in = 0, sie_ack = 0;
  logic rsp_valid, rsp_odd, rsp_keep, fifo_clr, irq;
  logic [1:0] rsp_code;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;

  int checks = 0, failures = 0;
  logic last_clr;
  bit done = 0;

  logic [3:0] exp_q[$];   // {code, odd, keep}
  string      tag_q[$];

  always #2 clk = ~clk;

  ctl_ep_status u0 (
    .clk(clk), .rst_n(rst_n), .sie_setup(sie_setup), .sie_out(sie_out),
    .sie_out_odd(sie_out_odd), .sie_in(sie_in), .sie_ack(sie_ack),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_odd(rsp_odd),
    .rsp_keep(rsp_keep), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_clr(fifo_clr), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected response", 1, 0);
      else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " code"}, rsp_code, e[3:2]);
        chk({t, " keep"}, rsp_keep, e[0]);
        if (e[3:2] == 2'd3) chk({t, " odd"}, rsp_odd, e[1]);
      end
    end
  end

  task automatic push(input string t, input logic [1:0] c, input logic o, input logic k);
    exp_q.push_back({c, o, k});
    tag_q.push_back(t);
  endtask

  task automatic do_setup(input string t);
    @(negedge clk); push(t, 2'd0, 1'b0, 1'b1); sie_setup = 1;
    @(negedge clk); sie_setup = 0;
  endtask

  task automatic do_out(input string t, input logic odd, input logic [1:0] c, input logic k);
    @(negedge clk); push(t, c, 1'b0, k); sie_out = 1; sie_out_odd = odd;
    @(negedge clk); sie_out = 0;
  endtask

  task automatic do_in(input string t, input logic [1:0] c, input logic o);
    @(negedge clk); push(t, c, o, 1'b0); sie_in = 1;
    @(negedge clk); sie_in = 0;
  endtask

  task automatic do_ack;
    @(negedge clk); sie_ack = 1;
    @(negedge clk); sie_ack = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; last_clr = fifo_clr;
  endtask

  task automatic rd(input string t, input logic [1:0] a, input int exp);
    cfg_addr = a; #0.5;
    chk(t, cfg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R10 reset status", 2'd0, 8'h00);
    rd("R11 reset enables", 2'd1, 8'h00);
    chk("R12 reset rsp_valid", rsp_valid, 0);
    chk("R11 reset irq", irq, 0);
    wr(2'd1, 8'h07);

    // control read: setup stage
    do_setup("R1 setup ack");
    rd("R1 R10 status after setup", 2'd0, 8'hC1);
    chk("R11 irq on setup", irq, 1);
    do_in("R3 IN while setup held", 2'd1, 1'b0);
    do_out("R3 OUT while setup held", 1'b1, 2'd1, 1'b0);
    rd("R3 status unchanged", 2'd0, 8'hC1);
    wr(2'd0, 8'h00);
    chk("R3 fifo_clr on setup release", last_clr, 1);
    chk("R11 irq after clear", irq, 0);
    rd("R3 status after release", 2'd0, 8'hC0);

    // IN data stage
    wr(2'd0, 8'h18);
    chk("R3 no fifo_clr", last_clr, 0);
    rd("R4 dir and txrdy", 2'd0, 8'hD8);
    do_in("R5 first IN data", 2'd3, 1'b1);
    do_ack;
    rd("R6 after ack", 2'd0, 8'h94);
    chk("R11 irq on complete", irq, 1);
    do_in("R5 IN while complete", 2'd1, 1'b0);
    do_ack;
    rd("R6 stray ack ignored", 2'd0, 8'h94);
    wr(2'd0, 8'h18);
    rd("R5 reload", 2'd0, 8'h98);
    do_in("R5 second IN data", 2'd3, 1'b0);
    do_ack;
    rd("R6 toggle back", 2'd0, 8'hD4);

    // status stage: zero-length OUT with DATA1
    wr(2'd0, 8'h00);
    chk("R3 clear cmpl no fifo_clr", last_clr, 0);
    rd("R4 dir back to 0", 2'd0, 8'hC0);
    do_out("R7 status OUT", 1'b1, 2'd0, 1'b1);
    rd("R7 out flag", 2'd0, 8'h42);
    do_out("R8 OUT while full", 1'b0, 2'd1, 1'b0);
    rd("R8 status unchanged", 2'd0, 8'h42);
    wr(2'd0, 8'h00);
    chk("R7 fifo_clr on out release", last_clr, 1);
    do_out("R9 parity mismatch", 1'b1, 2'd0, 1'b0);
    rd("R9 status unchanged", 2'd0, 8'h40);
    do_out("R7 parity match", 1'b0, 2'd0, 1'b1);
    rd("R7 out flag and toggle", 2'd0, 8'hC2);

    // stall
    wr(2'd0, 8'h20);
    chk("R7 fifo_clr with stall write", last_clr, 1);
    rd("R5 stall set", 2'd0, 8'hE0);
    do_in("R5 IN stalled", 2'd2, 1'b0);
    wr(2'd0, 8'h38);
    rd("R4 full set", 2'd0, 8'hF8);
    do_in("R5 stall beats data", 2'd2, 1'b0);
    do_setup("R1 setup clears stall");
    rd("R2 setup clears all", 2'd0, 8'hC1);

    // interrupt masking
    wr(2'd1, 8'h00);
    chk("R11 masked", irq, 0);
    wr(2'd1, 8'h01);
    chk("R11 unmasked", irq, 1);
    repeat (3) @(negedge clk);
    chk("R11 stays high", irq, 1);
    do_setup("R1 setup while setup set");
    rd("R1 setup again", 2'd0, 8'hC1);
    wr(2'd0, 8'h00);
    chk("R11 low after clear", irq, 0);

    repeat (3) @(negedge clk);
    chk("R12 no stray responses", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule